// File: doc/BRIEF.md
# USB IN Endpoint Interrupt Status Register

This block collects the event pulses produced by one IN endpoint of a USB device controller (protocol engine, transmit FIFO and DMA logic) into a 32-bit word of sticky status bits. Software reads the word over a minimal register bus and acknowledges events by writing ones to the bits it wants cleared. A per-bit mask input selects which status bits raise the single registered interrupt line.

Several status bits may only be set under certain operating modes. These include descriptor-based DMA, bus-master DMA, transmit thresholding, shared or per-endpoint FIFO, and the endpoint's transfer type and direction. An event that arrives while its bit is not permitted is dropped. One bit is a live, read-only view of the transmit FIFO fill level. A level-select input decides whether that bit means "half empty or better" or "completely empty". The packet-dropped bit is informational only and never reaches the interrupt line.

Top module: `usb_in_ep_irq`

## Requirements
- R1: While reset is held, the read word is 32'h0000_0080 (only the FIFO-empty bit 7 is 1) and `irq_o` is 0.
- R2: An event pulse on an unconditioned bit (bits 0, 1, 4, 5, 6, 11, 12, 13, 14 of `ev_i`) sets the same bit of the read word at the next clock edge, and the bit stays set until cleared.
- R3: When `wr_en_i` is 1, each 1 in `wr_data_i` clears the matching writable status bit at the next edge; 0 bits leave their status bits unchanged.
- R4: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: The buffer-not-available bit (bit 9) is set only while `sg_dma_i` is 1.
- R6: The timeout bit (bit 3) is never set while `sg_dma_i` is 1. Otherwise, with `shared_fifo_i`=1 it is set only for endpoint types other than isochronous, and with `shared_fifo_i`=0 only for control endpoints. `ep_type_i` encodes 0=control, 1=isochronous, 2=bulk, 3=interrupt.
- R7: The FIFO underrun bit (bit 8) is set only when `thr_en_i` is 1 and `ep_dir_in_i` is 1.
- R8: The bus error bit (bit 2) is set only while `int_dma_i` is 1.
- R9: Bit 7 follows `txf_fill_i` one cycle late. With `txf_full_only_i`=1 it is 1 only when the fill is 0. With `txf_full_only_i`=0 it is 1 when the fill is at most FIFO_DEPTH/2. Writes do not affect it.
- R10: Bit 10 and bits 31:15 always read as 0, whatever the events or writes.
- R11: A pulse on `cnak_i` clears the NAK-effective bit (bit 6) at the next edge.
- R12: `irq_o` is the OR, over all bits except bit 11, of read word AND `mask_i`, registered one cycle. Bit 11 never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 15 | One-cycle event pulses, one per status bit position |
| sg_dma_i | input | 1 | Descriptor-based DMA mode |
| int_dma_i | input | 1 | Bus-master DMA mode |
| thr_en_i | input | 1 | Transmit thresholding enabled |
| shared_fifo_i | input | 1 | 1: shared transmit FIFO, 0: per-endpoint FIFO |
| ep_type_i | input | 2 | Endpoint type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| ep_dir_in_i | input | 1 | Endpoint direction is IN |
| cnak_i | input | 1 | Clear-NAK command pulse |
| txf_fill_i | input | LVL_W | Transmit FIFO fill level in words |
| txf_full_only_i | input | 1 | 1: empty flag means completely empty, 0: half empty |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data, ones clear bits |
| mask_i | input | 32 | Interrupt mask, 1 enables the bit |
| rd_data_o | output | 32 | Status word |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that the mode inputs are steady around each event pulse. They also assume that `txf_fill_i` never exceeds FIFO_DEPTH, so the checks on the half-empty threshold compare against a legal fill. The bench changes modes only one full cycle before it pulses an event, and drives fills from 0 up to exactly FIFO_DEPTH. It also resets the status word with a write of all ones before each vector, so a sticky bit from a previous vector cannot mask a qualification error.

// File: rtl/usb_in_ep_irq_pkg.sv
package usb_in_ep_irq_pkg;
  localparam int unsigned STS_W  = 15;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_type_e;

  localparam int unsigned B_XFER    = 0;
  localparam int unsigned B_EPDIS   = 1;
  localparam int unsigned B_BUSERR  = 2;
  localparam int unsigned B_TMO     = 3;
  localparam int unsigned B_TKEMPTY = 4;
  localparam int unsigned B_TKMIS   = 5;
  localparam int unsigned B_NAKEFF  = 6;
  localparam int unsigned B_TXFE    = 7;
  localparam int unsigned B_UNDR    = 8;
  localparam int unsigned B_BNA     = 9;
  localparam int unsigned B_RSVD    = 10;
  localparam int unsigned B_PKTDROP = 11;
  localparam int unsigned B_BABBLE  = 12;
  localparam int unsigned B_NAK     = 13;
  localparam int unsigned B_NYET    = 14;

  // sticky flops exist only where software can clear
  localparam logic [STS_W-1:0] STICKY_MASK =
    ~((STS_W'(1) << B_RSVD) | (STS_W'(1) << B_TXFE));
  localparam logic [STS_W-1:0] IRQ_MASK = ~(STS_W'(1) << B_PKTDROP);
endpackage

// File: rtl/in_ep_evt_qual.sv
module in_ep_evt_qual
  import usb_in_ep_irq_pkg::*;
(
  input  logic [STS_W-1:0] ev_i,
  input  logic             sg_dma_i,
  input  logic             int_dma_i,
  input  logic             thr_en_i,
  input  logic             shared_fifo_i,
  input  logic [1:0]       ep_type_i,
  input  logic             ep_dir_in_i,
  output logic [STS_W-1:0] set_o
);
  logic [STS_W-1:0] allow;
  logic             tmo_type_ok;

  always_comb begin
    if (shared_fifo_i) tmo_type_ok = (ep_type_i != EP_ISO);
    else               tmo_type_ok = (ep_type_i == EP_CTRL);
  end

  always_comb begin
    allow            = STICKY_MASK;
    allow[B_BNA]     = sg_dma_i;
    allow[B_TMO]     = !sg_dma_i && tmo_type_ok;
    allow[B_UNDR]    = thr_en_i && ep_dir_in_i;
    allow[B_BUSERR]  = int_dma_i;
  end

  assign set_o = ev_i & allow;
endmodule

// File: rtl/in_ep_sticky.sv
module in_ep_sticky #(
  parameter int unsigned W = 15,
  parameter logic [W-1:0] PRESENT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (PRESENT[b]) begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[b]) q <= 1'b1;
        else if (clr_i[b]) q <= 1'b0;
      end
      assign q_o[b] = q;

      // R4
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[b] |=> q_o[b]);
      // R3
      w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[b] && !set_i[b]) |=> !q_o[b]);
      // R3
      hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[b] && !set_i[b]) |=> q_o[b] == $past(q_o[b]));
    end else begin : g_none
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/in_ep_txf_flag.sv
module in_ep_txf_flag #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fill_i,
  input  logic             full_only_i,
  output logic             empty_o
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

  logic empty_d;
  assign empty_d = full_only_i ? (fill_i == '0) : (fill_i <= HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_o <= 1'b1;
    else         empty_o <= empty_d;
  end

  // R9
  txf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == '0) |=> empty_o);
  // R9
  txf_above_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i > HALF) |=> !empty_o);
  // R9
  txf_full_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_only_i && fill_i != '0) |=> !empty_o);
endmodule

// File: rtl/usb_in_ep_irq.sv
module usb_in_ep_irq
  import usb_in_ep_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [14:0]       ev_i,
  input  logic              sg_dma_i,
  input  logic              int_dma_i,
  input  logic              thr_en_i,
  input  logic              shared_fifo_i,
  input  logic [1:0]        ep_type_i,
  input  logic              ep_dir_in_i,
  input  logic              cnak_i,
  input  logic [LVL_W-1:0]  txf_fill_i,
  input  logic              txf_full_only_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic [31:0]       mask_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  logic [STS_W-1:0] set_v, clr_v, sticky_q, word_lo;
  logic             txf_empty;
  logic             irq_d;

  in_ep_evt_qual u_qual (
    .ev_i          (ev_i),
    .sg_dma_i      (sg_dma_i),
    .int_dma_i     (int_dma_i),
    .thr_en_i      (thr_en_i),
    .shared_fifo_i (shared_fifo_i),
    .ep_type_i     (ep_type_i),
    .ep_dir_in_i   (ep_dir_in_i),
    .set_o         (set_v)
  );

  always_comb begin
    clr_v           = wr_en_i ? wr_data_i[STS_W-1:0] : '0;
    clr_v[B_NAKEFF] = clr_v[B_NAKEFF] | cnak_i;
  end

  in_ep_sticky #(.W(STS_W), .PRESENT(STICKY_MASK)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (sticky_q)
  );

  in_ep_txf_flag #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_txf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (txf_fill_i),
    .full_only_i (txf_full_only_i),
    .empty_o     (txf_empty)
  );

  always_comb begin
    word_lo         = sticky_q;
    word_lo[B_TXFE] = txf_empty;
  end

  assign rd_data_o = {{(WORD_W - STS_W){1'b0}}, word_lo};
  assign irq_d     = |(word_lo & mask_i[STS_W-1:0] & IRQ_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end

  // R5
  bna_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[B_BNA]) |-> $past(sg_dma_i));
  // R6
  tmo_no_sg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[B_TMO]) |-> !$past(sg_dma_i));
  // R7
  undr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[B_UNDR]) |-> ($past(thr_en_i) && $past(ep_dir_in_i)));
  // R8
  buserr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[B_BUSERR]) |-> $past(int_dma_i));
  // R11
  cnak_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnak_i && !ev_i[B_NAKEFF]) |=> !rd_data_o[B_NAKEFF]);
  // R12
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_o[STS_W-1:0] & mask_i[STS_W-1:0] & IRQ_MASK) == '0) |=> !irq_o);
  // R12
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_o[STS_W-1:0] & mask_i[STS_W-1:0] & IRQ_MASK) != '0) |=> irq_o);
endmodule

// File: tb/sim_usb_in_ep_irq.sv
module sim_usb_in_ep_irq;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [3:0]  req;
    logic [14:0] ev;
    logic        sg, idma, thr, shr;
    logic [1:0]  typ;
    logic        din;
    logic [14:0] exp;
  } vec_t;

  // R2 R5 R6 R7 R8 R10: event, modes, expected sticky bits (bit 7 masked off)
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  15'h0001, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b1, 15'h0001},
    '{4'd5,  15'h0200, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b1, 15'h0000},
    '{4'd5,  15'h0200, 1'b1,1'b0,1'b0,1'b0, 2'd2, 1'b1, 15'h0200},
    '{4'd6,  15'h0008, 1'b1,1'b0,1'b0,1'b1, 2'd2, 1'b1, 15'h0000},
    '{4'd6,  15'h0008, 1'b0,1'b0,1'b0,1'b1, 2'd2, 1'b1, 15'h0008},
    '{4'd6,  15'h0008, 1'b0,1'b0,1'b0,1'b1, 2'd1, 1'b1, 15'h0000},
    '{4'd6,  15'h0008, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1, 15'h0008},
    '{4'd6,  15'h0008, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b1, 15'h0000},
    '{4'd7,  15'h0100, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b1, 15'h0000},
    '{4'd7,  15'h0100, 1'b0,1'b0,1'b1,1'b0, 2'd2, 1'b1, 15'h0100},
    '{4'd7,  15'h0100, 1'b0,1'b0,1'b1,1'b0, 2'd2, 1'b0, 15'h0000},
    '{4'd8,  15'h0004, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b1, 15'h0000},
    '{4'd8,  15'h0004, 1'b0,1'b1,1'b0,1'b0, 2'd2, 1'b1, 15'h0004},
    '{4'd10, 15'h7FFF, 1'b0,1'b1,1'b1,1'b1, 2'd2, 1'b1, 15'h797F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] ev = '0;
  logic sg = 0, idma = 0, thr = 0, shr = 0, din = 1, cnak = 0, full_only = 0, wr_en = 0;
  logic [1:0] typ = 2'd2;
  logic [LW-1:0] fill = '0;
  logic [31:0] wdata = '0, mask = '0, rd;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_in_ep_irq #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .sg_dma_i(sg), .int_dma_i(idma),
    .thr_en_i(thr), .shared_fifo_i(shr), .ep_type_i(typ), .ep_dir_in_i(din),
    .cnak_i(cnak), .txf_fill_i(fill), .txf_full_only_i(full_only),
    .wr_en_i(wr_en), .wr_data_i(wdata), .mask_i(mask), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clear_all();
    wr_en = 1; wdata = '1; tick(); wr_en = 0; wdata = '0;
  endtask

  task automatic pulse(input logic [14:0] e);
    ev = e; tick(); ev = '0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk(1, rd, 32'h0000_0080);
    chk(1, {31'b0, irq}, 32'h0);
    rst_n = 1; tick();

    for (int i = 0; i < NV; i++) begin
      sg = VECS[i].sg; idma = VECS[i].idma; thr = VECS[i].thr;
      shr = VECS[i].shr; typ = VECS[i].typ; din = VECS[i].din;
      clear_all();
      pulse(VECS[i].ev);
      chk(int'(VECS[i].req), rd & 32'hFFFF_FF7F, {17'b0, VECS[i].exp});
    end
    sg = 0; idma = 0; thr = 0; shr = 0; typ = 2'd2; din = 1;

    // R2 / R3: sticky, write 0 ignored, write 1 clears
    clear_all();
    pulse(15'h0003);
    tick();
    chk(2, rd & 32'hFF7F, 32'h0003);
    wr_en = 1; wdata = 32'h0; tick(); wr_en = 0;
    chk(3, rd & 32'hFF7F, 32'h0003);
    wr_en = 1; wdata = 32'h1; tick(); wr_en = 0; wdata = '0;
    chk(3, rd & 32'hFF7F, 32'h0002);

    // R4: set beats clear
    wr_en = 1; wdata = 32'h3; ev = 15'h0001; tick();
    wr_en = 0; wdata = '0; ev = '0;
    chk(4, rd & 32'hFF7F, 32'h0001);

    // R11: clear-NAK command
    clear_all();
    pulse(15'h0040);
    chk(11, rd & 32'hFF7F, 32'h0040);
    cnak = 1; tick(); cnak = 0;
    chk(11, rd & 32'hFF7F, 32'h0000);

    // R9: live FIFO-empty level
    fill = LW'(DEPTH / 2); full_only = 0; tick();
    chk(9, {31'b0, rd[7]}, 32'h1);
    full_only = 1; tick();
    chk(9, {31'b0, rd[7]}, 32'h0);
    full_only = 0; fill = LW'(DEPTH / 2 + 1); tick();
    chk(9, {31'b0, rd[7]}, 32'h0);
    fill = '0; full_only = 1; tick();
    chk(9, {31'b0, rd[7]}, 32'h1);
    wr_en = 1; wdata = 32'h80; tick(); wr_en = 0; wdata = '0;
    chk(9, {31'b0, rd[7]}, 32'h1);

    // R10: reserved bits survive all-ones events and writes
    wr_en = 1; wdata = '1; ev = 15'h7FFF; tick(); wr_en = 0; wdata = '0; ev = '0;
    chk(10, rd & 32'hFFFF_8400, 32'h0);

    // R12: masked interrupt, packet-dropped bit excluded
    clear_all();
    fill = LW'(DEPTH); full_only = 0; mask = '1; tick();
    pulse(15'h0800);
    tick();
    chk(12, {31'b0, irq}, 32'h0);
    chk(12, rd & 32'hFFFF, 32'h0800);
    mask = 32'h2000;
    pulse(15'h2000);
    chk(12, {31'b0, irq}, 32'h0);
    tick();
    chk(12, {31'b0, irq}, 32'h1);
    mask = 32'h0; tick();
    chk(12, {31'b0, irq}, 32'h0);
    clear_all();
    mask = 32'h80; fill = '0; tick();
    chk(12, {31'b0, irq}, 32'h0);
    tick();
    chk(12, {31'b0, irq}, 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule